// File: doc/BRIEF.md
# Prioritised Interrupt Flag Register

This block is the read-only cause register behind a host interrupt line. Four event pulses come in from controller logic: mailbox-in-full, mailbox-out-available, adapter-command-complete and command-done. The block turns them into flag bits under a set of deferral rules. It keeps a summary bit and drives the host interrupt line. The host reads the byte to learn why it was interrupted, then pulses an interrupt-reset strobe to clear every posted flag.

The mailbox events are held back while a completion flag (adapter-complete or command-done) is showing. The two completion events are held back until no interrupt is active and the data-full flag is low. An event that cannot be posted is kept in a pending latch and is posted once the rules allow it, so no event is lost. Pending events are examined again on the cycle after a clear. A held event therefore shows up one cycle after the clear.

A power-on reset (asynchronous, active low) clears all state. So do the hard-reset and soft-reset pulses, which are synchronous.

Top module: `irq_flag_reg`

## Requirements
- R1: The byte reads as follows: bit 0 is mailbox-in-full, bit 1 is mailbox-out-available, bit 2 is adapter-complete, bit 3 is command-done, bits 4 to 6 always read 0, and bit 7 is the summary bit.
- R2: When any flag bit is posted, bit 7 and `host_irq` go high in the same cycle as that flag, and both stay high until a clear.
- R3: An event sampled at a rising edge, with no completion flag showing, appears in the byte right after that edge.
- R4: A mailbox event that arrives while bit 2 or bit 3 is set is held. It is posted at the edge after the interrupt-reset edge.
- R5: A completion event is posted only at an edge where bit 7 is 0 and `data_full` is 0. Otherwise it is held until both conditions are met.
- R6: `irq_reset` clears bits 0 to 3, bit 7 and `host_irq` at the next edge, and nothing is posted at that edge. Events that arrive with the strobe are kept pending.
- R7: `hard_rst` or `soft_rst` clears the flags, the line and every pending event at the next edge. A low level on `por_n` clears all of them at once.
- R8: A mailbox-out-available pulse is ignored, and is neither posted nor kept pending, when `mbo_int_en` is low in its cycle.
- R9: A held event stays pending until it is posted, and it is posted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hard_rst | input | 1 | Hard reset pulse, synchronous |
| soft_rst | input | 1 | Soft reset pulse, synchronous |
| irq_reset | input | 1 | Interrupt-reset strobe from the host |
| mbo_int_en | input | 1 | Enables the mailbox-out-available event |
| data_full | input | 1 | Data-full flag, which blocks completion posting |
| ev_mbox_in | input | 1 | Mailbox-in-full event pulse |
| ev_mbox_out | input | 1 | Mailbox-out-available event pulse |
| ev_adp_cmplt | input | 1 | Adapter-command-complete event pulse |
| ev_cmd_done | input | 1 | Command-done event pulse |
| flag_byte | output | 8 | Interrupt flag byte |
| host_irq | output | 1 | Host interrupt line |

## Verification
Every result comes from one register stage. An event or strobe driven in a cycle shows in `flag_byte` and `host_irq` just after the next rising edge. A held event appears one edge after the clear that releases it. The bench drives inputs on the falling edge and samples on the following falling edge. The one exception is the asynchronous `por_n`: its effect is checked a few nanoseconds after it falls, with no clock edge in between. The table vectors chain held events across clears, so each deferred posting is checked in exactly the cycle where it is due.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int NSRC    = 4;
  localparam int REG_W   = 8;
  localparam int SUM_BIT = 7;
  localparam int B_MBI   = 0;
  localparam int B_MBO   = 1;
  localparam int B_ADP   = 2;
  localparam int B_CMD   = 3;

  function automatic logic [NSRC-1:0] mbox_mask();
    logic [NSRC-1:0] m;
    m = '0;
    m[B_MBI] = 1'b1;
    m[B_MBO] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSRC-1:0] cmpl_mask();
    logic [NSRC-1:0] m;
    m = '0;
    m[B_ADP] = 1'b1;
    m[B_CMD] = 1'b1;
    return m;
  endfunction

  // Reserved bits read zero; summary at SUM_BIT.
  function automatic logic [REG_W-1:0] pack_flags(input logic sum, input logic [NSRC-1:0] f);
    logic [REG_W-1:0] b;
    b = '0;
    b[NSRC-1:0] = f;
    b[SUM_BIT]  = sum;
    return b;
  endfunction
endpackage

// File: rtl/irqf_pending.sv
module irqf_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         sync_clr,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] take_vec,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        pend_q[i] <= 1'b0;
      else if (sync_clr) pend_q[i] <= 1'b0;
      else               pend_q[i] <= (pend_q[i] | set_vec[i]) & ~take_vec[i];
    end

    // R9: an event that is not taken is remembered
    assert_pend_kept_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!sync_clr && set_vec[i] && !take_vec[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/irqf_arbiter.sv
module irqf_arbiter
  import irqf_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] req_vec,
  input  logic [N-1:0] flags_q,
  input  logic         any_q,
  input  logic         data_full,
  input  logic         clr,
  output logic [N-1:0] post_vec
);
  logic cmpl_showing;
  logic mb_ok;
  logic cmpl_ok;

  always_comb begin
    cmpl_showing = |(flags_q & cmpl_mask());
    mb_ok        = !clr && !cmpl_showing;
    cmpl_ok      = !clr && !any_q && !data_full;
    post_vec     = req_vec & ((mbox_mask() & {N{mb_ok}}) | (cmpl_mask() & {N{cmpl_ok}}));
  end

  // R4: mailbox never posted while a completion flag is showing
  assert_mbox_deferred_R4: assert property (@(posedge clk) disable iff (!por_n)
    (|(post_vec & mbox_mask())) |-> !(|(flags_q & cmpl_mask())));

  // R5: completion only when idle and data-full low
  assert_cmpl_gate_R5: assert property (@(posedge clk) disable iff (!por_n)
    (|(post_vec & cmpl_mask())) |-> (!any_q && !data_full));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int N_EV = NSRC,
  parameter int W    = REG_W
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         hard_rst,
  input  logic         soft_rst,
  input  logic         irq_reset,
  input  logic         mbo_int_en,
  input  logic         data_full,
  input  logic         ev_mbox_in,
  input  logic         ev_mbox_out,
  input  logic         ev_adp_cmplt,
  input  logic         ev_cmd_done,
  output logic [W-1:0] flag_byte,
  output logic         host_irq
);
  logic [N_EV-1:0] ev_vec;
  logic [N_EV-1:0] pend_q;
  logic [N_EV-1:0] req_vec;
  logic [N_EV-1:0] post_vec;
  logic [N_EV-1:0] flags_q;
  logic            any_q;
  logic            sync_clr;

  always_comb begin
    ev_vec        = '0;
    ev_vec[B_MBI] = ev_mbox_in;
    ev_vec[B_MBO] = ev_mbox_out & mbo_int_en;
    ev_vec[B_ADP] = ev_adp_cmplt;
    ev_vec[B_CMD] = ev_cmd_done;
    sync_clr      = hard_rst | soft_rst;
    req_vec       = pend_q | ev_vec;
  end

  irqf_pending #(.N(N_EV)) pend_i (
    .clk(clk), .por_n(por_n), .sync_clr(sync_clr),
    .set_vec(ev_vec), .take_vec(post_vec), .pend_q(pend_q)
  );

  irqf_arbiter #(.N(N_EV)) arb_i (
    .clk(clk), .por_n(por_n), .req_vec(req_vec), .flags_q(flags_q),
    .any_q(any_q), .data_full(data_full), .clr(irq_reset | sync_clr),
    .post_vec(post_vec)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags_q <= '0;
      any_q   <= 1'b0;
    end else if (sync_clr || irq_reset) begin
      flags_q <= '0;
      any_q   <= 1'b0;
    end else begin
      flags_q <= flags_q | post_vec;
      any_q   <= any_q | (|post_vec);
    end
  end

  assign flag_byte = pack_flags(any_q, flags_q);
  assign host_irq  = any_q;

  // R2: summary register tracks the cause bits
  assert_summary_R2: assert property (@(posedge clk) disable iff (!por_n)
    any_q == (|flags_q));

  // R6: strobe empties the register at the next edge
  assert_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
    irq_reset |=> (flags_q == '0 && !host_irq));

  // R7: hard or soft reset wipes flags and pending
  assert_sync_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
    sync_clr |=> (flags_q == '0 && pend_q == '0 && !host_irq));

  // R8: disabled mailbox-out pulse leaves no trace
  assert_mbo_masked_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!mbo_int_en && !pend_q[B_MBO] && !flags_q[B_MBO]) |=> (!pend_q[B_MBO] && !flags_q[B_MBO]));
endmodule

// File: tb/irq_flag_reg_tb.sv
`timescale 1ns/1ps
module irq_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       hard_rst = 1'b0, soft_rst = 1'b0, irq_reset = 1'b0;
  logic       mbo_int_en = 1'b0, data_full = 1'b0;
  logic       ev_mbox_in = 1'b0, ev_mbox_out = 1'b0, ev_adp_cmplt = 1'b0, ev_cmd_done = 1'b0;
  logic [7:0] flag_byte;
  logic       host_irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_flag_reg dut_i (
    .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .irq_reset(irq_reset), .mbo_int_en(mbo_int_en), .data_full(data_full),
    .ev_mbox_in(ev_mbox_in), .ev_mbox_out(ev_mbox_out),
    .ev_adp_cmplt(ev_adp_cmplt), .ev_cmd_done(ev_cmd_done),
    .flag_byte(flag_byte), .host_irq(host_irq)
  );

  // {clr, en, df, cmd, adp, mbo, mbi, expected byte}; bit0 mbi, bit1 mbo, bit2 adp, bit3 cmd, bit7 summary
  localparam int NV = 24;
  localparam logic [14:0] TBL [NV] = '{
    15'b0_0_0_0000_00000000, // 0  idle
    15'b0_0_0_0001_10000001, // 1  mbi immediate
    15'b0_0_0_0000_10000001, // 2  held
    15'b1_0_0_0000_00000000, // 3  clear
    15'b0_1_0_0010_10000010, // 4  mbo enabled
    15'b1_0_0_0000_00000000, // 5  clear
    15'b0_0_0_0010_00000000, // 6  mbo disabled
    15'b0_0_0_0000_00000000, // 7  not pending
    15'b0_0_0_1000_10001000, // 8  cmd done
    15'b0_1_0_0011_10001000, // 9  mailboxes held
    15'b1_0_0_0000_00000000, // 10 clear
    15'b0_0_0_0000_10000011, // 11 held mailboxes appear
    15'b0_0_0_0100_10000011, // 12 adp held (summary set)
    15'b1_0_0_0000_00000000, // 13 clear
    15'b0_0_0_0000_10000100, // 14 adp appears
    15'b1_0_0_0000_00000000, // 15 clear
    15'b0_0_1_1000_00000000, // 16 cmd held by data-full
    15'b0_0_1_0000_00000000, // 17 still held
    15'b0_0_0_0000_10001000, // 18 data-full low -> cmd
    15'b1_0_0_0001_00000000, // 19 clear with mbi arriving
    15'b0_0_0_0000_10000001, // 20 mbi appears
    15'b1_0_0_0000_00000000, // 21 clear
    15'b0_0_0_0101_10000101, // 22 mbi + adp together
    15'b1_0_0_0000_00000000  // 23 clear
  };

  function automatic string tag_of(int i);
    case (i)
      1, 2, 22:            return "R3";
      4, 6, 7:             return "R8";
      9, 11, 12:           return "R4";
      14, 16, 17, 18:      return "R5";
      20:                  return "R9";
      default:             return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] exp_b);
    n_run++;
    if (flag_byte !== exp_b || host_irq !== exp_b[7]) begin
      n_fail++;
      $display("FAIL %s: byte=%02h irq=%0b expected byte=%02h irq=%0b",
               req, flag_byte, host_irq, exp_b, exp_b[7]);
    end
  endtask

  task automatic drive_step(logic clr, logic en, logic df, logic [3:0] ev);
    irq_reset = clr; mbo_int_en = en; data_full = df;
    ev_mbox_in = ev[0]; ev_mbox_out = ev[1]; ev_adp_cmplt = ev[2]; ev_cmd_done = ev[3];
    @(posedge clk);
    @(negedge clk);
    irq_reset = 1'b0; ev_mbox_in = 1'b0; ev_mbox_out = 1'b0;
    ev_adp_cmplt = 1'b0; ev_cmd_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", 8'h00);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release", 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive_step(TBL[i][14], TBL[i][13], TBL[i][12], TBL[i][11:8]);
      check(tag_of(i), TBL[i][7:0]);
      if (flag_byte[6:4] !== 3'b000) begin
        n_run++; n_fail++;
        $display("FAIL R1: reserved=%0b expected=000", flag_byte[6:4]);
      end
      if (TBL[i][7]) begin
        n_run++;
        if (host_irq !== 1'b1) begin
          n_fail++;
          $display("FAIL R2: irq=%0b expected=1", host_irq);
        end
      end
    end

    // R7: hard reset wipes posted and pending events
    drive_step(1'b0, 1'b0, 1'b0, 4'b1000);
    check("R7 setup", 8'h88);
    drive_step(1'b0, 1'b0, 1'b0, 4'b0001);
    check("R7 mbi held", 8'h88);
    hard_rst = 1'b1;
    drive_step(1'b0, 1'b0, 1'b0, 4'b0000);
    hard_rst = 1'b0;
    check("R7 hard reset", 8'h00);
    drive_step(1'b1, 1'b0, 1'b0, 4'b0000);
    drive_step(1'b0, 1'b0, 1'b0, 4'b0000);
    check("R7 pending wiped by hard reset", 8'h00);

    // R7: soft reset
    drive_step(1'b0, 1'b0, 1'b0, 4'b0001);
    check("R7 soft setup", 8'h81);
    soft_rst = 1'b1;
    drive_step(1'b0, 1'b0, 1'b0, 4'b0000);
    soft_rst = 1'b0;
    check("R7 soft reset", 8'h00);

    // R7: power-on reset acts without a clock edge
    drive_step(1'b0, 1'b0, 1'b0, 4'b0100);
    check("R7 por setup", 8'h84);
    #1 por_n = 1'b0;
    #1 check("R7 power-on reset", 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R9: held completion posted exactly once
    drive_step(1'b0, 1'b0, 1'b0, 4'b0001);
    drive_step(1'b0, 1'b0, 1'b0, 4'b1000);
    check("R9 cmd held behind mbi", 8'h81);
    drive_step(1'b1, 1'b0, 1'b0, 4'b0000);
    drive_step(1'b0, 1'b0, 1'b0, 4'b0000);
    check("R9 cmd posted", 8'h88);
    drive_step(1'b1, 1'b0, 1'b0, 4'b0000);
    drive_step(1'b0, 1'b0, 1'b0, 4'b0000);
    check("R9 not reposted", 8'h00);

    finish_run();
  end
endmodule